// File: doc/BRIEF.md
# PCIe Root Port Message Interrupt Aggregator

This block collects interrupt events for one PCIe root port and hands them to a host processor as a single level-sensitive interrupt line. Inbound memory writes that the link layer has already decoded arrive on a sideband port as an address and a data word. When the address equals the value software has programmed as the message target, the data word is taken as a vector number, and the matching bit of a 32-bit pending word is set. The same event also sets a sticky summary flag in a shared status word. Four legacy INTx levels are shown live in the same status word.

Software sees a small register file on a 32-bit read/write port. It programs the target address, masks sources, reads the pending word and clears serviced vectors by writing ones to them. When the pending word reads zero, software clears the summary flag with a separate write. Because each new arrival sets the summary again, a message that lands after the drain is not lost. The interrupt line is the OR of the unmasked summary flag and the unmasked INTx levels.

Top module: `msi_irq_ctrl`

## Requirements
- R1: After reset the pending word and the summary flag are 0, the target address register is 0, and the mask register reads 0x008F0000 (bits 23 and 19:16 set, so all sources are masked).
- R2: An inbound write whose address equals the target address register and whose data value N is below 32 sets pending bit N and the summary flag (status bit 23) at the next clock edge.
- R3: An inbound write with a data value of 32 or more, or with an address that differs from the target address register, changes neither the pending word nor the summary flag.
- R4: A register write to the pending word (offset 0x42C) clears every pending bit whose write-data bit is 1 and leaves bits written with 0 unchanged.
- R5: Writing 1 to bit 23 of the status word (offset 0x424) clears the summary flag without touching the pending word. Writing 0 to bit 23 has no effect.
- R6: If a software clear and a new arrival reach the same pending bit, or the summary flag, in the same cycle, that bit is set afterwards.
- R7: Status bits 19:16 read the live levels of INTx inputs 3..0. All other status bits except bit 23 read 0.
- R8: irqOut is high exactly when (summary is 1 and mask bit 23 is 0) or (some intxIn[i] is 1 while mask bit 16+i is 0).
- R9: The mask register (offset 0x420) stores only bits 23 and 19:16, and the others read 0. The target address register (offset 0x430) stores all 32 bits.
- R10: A read presented in one cycle returns its data on regRdData after the next clock edge. Unmapped offsets read 0, and writes to them change no register.
- R11: After the pending word has been drained and the summary cleared, a new accepted arrival sets the summary flag again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 12 | Register byte offset |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdEn | input | 1 | Register read strobe |
| regRdData | output | 32 | Read data, valid the cycle after regRdEn |
| inWrValid | input | 1 | Inbound write event valid |
| inWrAddr | input | 32 | Inbound write address (low 32 bits) |
| inWrData | input | 32 | Inbound write data, the vector number |
| intxIn | input | 4 | Legacy INTx levels, bit 0 = INTA |
| irqOut | output | 1 | Level interrupt to the host |

## Verification
A software write-1-to-clear and an inbound arrival can land in the same cycle, on the same pending bit or on the summary flag. The bench provokes this by driving the register write and the sideband event on the same clock edge. It does this once for the same vector, once for different vectors, and once with a summary clear against a new arrival. It then reads the pending and status words and expects the arriving bits to be set and only the other cleared bits to be gone.

// File: rtl/msi_irq_pkg.sv
package msi_irq_pkg;
  localparam int REG_AW = 12;
  localparam int WORD_W = 32;
  localparam logic [REG_AW-1:0] OFF_MASK = 12'h420;
  localparam logic [REG_AW-1:0] OFF_STAT = 12'h424;
  localparam logic [REG_AW-1:0] OFF_PEND = 12'h42c;
  localparam logic [REG_AW-1:0] OFF_TADDR = 12'h430;
  localparam int SUM_BIT = 23;
  localparam int INTX_LO = 16;
  localparam int INTX_N = 4;

  typedef enum logic [2:0] {
    RD_NONE, RD_MASK, RD_STAT, RD_PEND, RD_TADDR
  } rdSel_e;

  typedef struct packed {
    logic   wrMask;
    logic   wrStat;
    logic   wrPend;
    logic   wrTaddr;
    logic   rdEn;
    rdSel_e rdSel;
  } regStrobe_t;
endpackage

// File: rtl/msi_reg_decode.sv
module msi_reg_decode
  import msi_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_AW-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              regRdEn,
  output regStrobe_t        strobe
);
  logic hitMask, hitStat, hitPend, hitTaddr;

  always_comb begin
    hitMask  = (regAddr == OFF_MASK);
    hitStat  = (regAddr == OFF_STAT);
    hitPend  = (regAddr == OFF_PEND);
    hitTaddr = (regAddr == OFF_TADDR);
  end

  always_comb begin
    strobe.wrMask  = regWrEn && hitMask;
    strobe.wrStat  = regWrEn && hitStat;
    strobe.wrPend  = regWrEn && hitPend;
    strobe.wrTaddr = regWrEn && hitTaddr;
    strobe.rdEn    = regRdEn;
    if (!regRdEn)      strobe.rdSel = RD_NONE;
    else if (hitMask)  strobe.rdSel = RD_MASK;
    else if (hitStat)  strobe.rdSel = RD_STAT;
    else if (hitPend)  strobe.rdSel = RD_PEND;
    else if (hitTaddr) strobe.rdSel = RD_TADDR;
    else               strobe.rdSel = RD_NONE;
  end

  // R10: at most one register is written per cycle
  p_one_write_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrMask, strobe.wrStat, strobe.wrPend, strobe.wrTaddr}));
endmodule

// File: rtl/msi_irq_datapath.sv
module msi_irq_datapath
  import msi_irq_pkg::*;
#(
  parameter int NUM_VEC = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobe,
  input  logic [WORD_W-1:0] regWrData,
  input  logic              inWrValid,
  input  logic [WORD_W-1:0] inWrAddr,
  input  logic [WORD_W-1:0] inWrData,
  input  logic [INTX_N-1:0] intxIn,
  output logic [WORD_W-1:0] regRdData,
  output logic              irqOut
);
  localparam int VEC_W = $clog2(NUM_VEC);

  logic [NUM_VEC-1:0] pendQ, setVec, clrVec;
  logic               summaryQ;
  logic               msiMaskQ;
  logic [INTX_N-1:0]  intxMaskQ;
  logic [WORD_W-1:0]  taddrQ;
  logic [VEC_W-1:0]   vecIdx;
  logic               inRange, msiHit, sumClr;
  logic [WORD_W-1:0]  rdMux;

  always_comb begin
    vecIdx  = inWrData[VEC_W-1:0];
    inRange = (inWrData < WORD_W'(NUM_VEC));
    msiHit  = inWrValid && (inWrAddr == taddrQ) && inRange;
    clrVec  = strobe.wrPend ? regWrData[NUM_VEC-1:0] : '0;
    sumClr  = strobe.wrStat && regWrData[SUM_BIT];
  end

  for (genvar g = 0; g < NUM_VEC; g++) begin : g_set
    assign setVec[g] = msiHit && (vecIdx == VEC_W'(g));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ    <= '0;
      summaryQ <= 1'b0;
    end else begin
      pendQ    <= (pendQ & ~clrVec) | setVec;
      summaryQ <= msiHit || (summaryQ && !sumClr);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      msiMaskQ  <= 1'b1;
      intxMaskQ <= '1;
      taddrQ    <= '0;
    end else begin
      if (strobe.wrMask) begin
        msiMaskQ  <= regWrData[SUM_BIT];
        intxMaskQ <= regWrData[INTX_LO +: INTX_N];
      end
      if (strobe.wrTaddr) taddrQ <= regWrData;
    end
  end

  always_comb begin
    rdMux = '0;
    case (strobe.rdSel)
      RD_MASK: begin
        rdMux[SUM_BIT]            = msiMaskQ;
        rdMux[INTX_LO +: INTX_N]  = intxMaskQ;
      end
      RD_STAT: begin
        rdMux[SUM_BIT]            = summaryQ;
        rdMux[INTX_LO +: INTX_N]  = intxIn;
      end
      RD_PEND:  rdMux[NUM_VEC-1:0] = pendQ;
      RD_TADDR: rdMux = taddrQ;
      default:  rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)            regRdData <= '0;
    else if (strobe.rdEn) regRdData <= rdMux;
  end

  assign irqOut = (summaryQ && !msiMaskQ) || (|(intxIn & ~intxMaskQ));

  // R2: an accepted arrival is pending after the edge
  p_hit_sets_r2: assert property (@(posedge clk) disable iff (!rstN)
    msiHit |=> pendQ[$past(vecIdx)]);
  // R11: every accepted arrival raises the summary
  p_hit_summary_r11: assert property (@(posedge clk) disable iff (!rstN)
    msiHit |=> summaryQ);
  // R3: without an accepted arrival or a clear, pending holds
  p_pend_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!msiHit && !strobe.wrPend) |=> $stable(pendQ));
  // R4: a clear without arrival removes every written bit
  p_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrPend && !msiHit) |=> ((pendQ & $past(regWrData[NUM_VEC-1:0])) == '0));
  // R5: the summary never rises without an arrival
  p_sum_rise_r5: assert property (@(posedge clk) disable iff (!rstN)
    !msiHit |=> !$rose(summaryQ));
  // R8: fully masked means no interrupt
  p_all_masked_r8: assert property (@(posedge clk) disable iff (!rstN)
    (msiMaskQ && (&intxMaskQ)) |-> !irqOut);
endmodule

// File: rtl/msi_irq_ctrl.sv
module msi_irq_ctrl
  import msi_irq_pkg::*;
#(
  parameter int NUM_VEC = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_AW-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [WORD_W-1:0] regWrData,
  input  logic              regRdEn,
  output logic [WORD_W-1:0] regRdData,
  input  logic              inWrValid,
  input  logic [WORD_W-1:0] inWrAddr,
  input  logic [WORD_W-1:0] inWrData,
  input  logic [INTX_N-1:0] intxIn,
  output logic              irqOut
);
  regStrobe_t strobe;

  msi_reg_decode uDecode (
    .clk     (clk),
    .rstN    (rstN),
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .regRdEn (regRdEn),
    .strobe  (strobe)
  );

  msi_irq_datapath #(.NUM_VEC(NUM_VEC)) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .regWrData (regWrData),
    .inWrValid (inWrValid),
    .inWrAddr  (inWrAddr),
    .inWrData  (inWrData),
    .intxIn    (intxIn),
    .regRdData (regRdData),
    .irqOut    (irqOut)
  );
endmodule

// File: tb/msi_irq_ctrl_test.sv
module msi_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic        regRdEn = 1'b0;
  logic [31:0] regRdData;
  logic        inWrValid = 1'b0;
  logic [31:0] inWrAddr = '0;
  logic [31:0] inWrData = '0;
  logic [3:0]  intxIn = '0;
  logic        irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam logic [11:0] A_MASK = 12'h420, A_STAT = 12'h424,
                          A_PEND = 12'h42c, A_TADDR = 12'h430;
  localparam logic [31:0] TGT = 32'h1234_00c0;
  localparam logic [31:0] SUMB = 32'h0080_0000;

  always #5 clk = ~clk;

  msi_irq_ctrl uut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdEn(regRdEn), .regRdData(regRdData),
    .inWrValid(inWrValid), .inWrAddr(inWrAddr), .inWrData(inWrData),
    .intxIn(intxIn), .irqOut(irqOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic [11:0] a, input logic [31:0] wd,
                      input logic iv, input logic [31:0] ia, input logic [31:0] id);
    @(negedge clk);
    regWrEn = we; regAddr = a; regWrData = wd;
    inWrValid = iv; inWrAddr = ia; inWrData = id;
    @(negedge clk);
    regWrEn = 1'b0; inWrValid = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] wd);
    step(1'b1, a, wd, 1'b0, '0, '0);
  endtask

  task automatic msi(input logic [31:0] ia, input logic [31:0] id);
    step(1'b0, 12'h0, '0, 1'b1, ia, id);
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    @(negedge clk);
    regRdEn = 1'b0;
    d = regRdData;
  endtask

  initial begin
    for (int c = 0; c < 200000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] pendExp;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rd(A_MASK, d);  chk("R1 mask", d, 32'h008F_0000);
    rd(A_STAT, d);  chk("R1 status", d, 32'h0);
    rd(A_PEND, d);  chk("R1 pending", d, 32'h0);
    rd(A_TADDR, d); chk("R1 target", d, 32'h0);
    chk("R1 irqOut", {31'b0, irqOut}, 32'h0);

    // R9 register storage
    wr(A_TADDR, TGT);
    rd(A_TADDR, d); chk("R9 target", d, TGT);
    wr(A_MASK, 32'hFFFF_FFFF);
    rd(A_MASK, d); chk("R9 mask ones", d, 32'h008F_0000);
    wr(A_MASK, 32'h0);
    rd(A_MASK, d); chk("R9 mask zero", d, 32'h0);

    // R2 and R4 sweep over every vector
    for (int n = 0; n < 32; n++) begin
      msi(TGT, n);
      rd(A_PEND, d); chk("R2 pending bit", d, 32'h1 << n);
      rd(A_STAT, d); chk("R2 summary", d, SUMB);
      wr(A_PEND, 32'h1 << n);
      wr(A_STAT, SUMB);
      rd(A_PEND, d); chk("R4 cleared", d, 32'h0);
    end
    rd(A_STAT, d); chk("R5 summary cleared", d, 32'h0);

    // R3 out-of-range data and address mismatch
    for (int v = 32; v < 48; v++) msi(TGT, v);
    for (int k = 0; k < 32; k++) msi(TGT ^ (32'h1 << k), 3);
    msi(TGT, 32'h8000_0001);
    rd(A_PEND, d); chk("R3 pending untouched", d, 32'h0);
    rd(A_STAT, d); chk("R3 summary untouched", d, 32'h0);

    // R4 partial clears
    for (int n = 0; n < 32; n++) msi(TGT, n);
    rd(A_PEND, d); chk("R4 all set", d, 32'hFFFF_FFFF);
    wr(A_PEND, 32'hA5A5_A5A5);
    rd(A_PEND, d); chk("R4 partial clear", d, 32'h5A5A_5A5A);
    wr(A_PEND, 32'h0);
    rd(A_PEND, d); chk("R4 zero write", d, 32'h5A5A_5A5A);

    // R5 summary independent of pending
    wr(A_STAT, 32'hFF7F_FFFF);
    rd(A_STAT, d); chk("R5 bit23 zero no effect", d, SUMB);
    wr(A_STAT, SUMB);
    rd(A_STAT, d); chk("R5 summary clear", d, 32'h0);
    rd(A_PEND, d); chk("R5 pending kept", d, 32'h5A5A_5A5A);

    // R11 drain then re-arm
    wr(A_PEND, 32'hFFFF_FFFF);
    rd(A_PEND, d); chk("R11 drained", d, 32'h0);
    msi(TGT, 9);
    rd(A_STAT, d); chk("R11 summary again", d, SUMB);
    rd(A_PEND, d); chk("R11 pending", d, 32'h1 << 9);

    // R6 same-cycle clear and arrival
    step(1'b1, A_PEND, 32'h1 << 9, 1'b1, TGT, 9);
    rd(A_PEND, d); chk("R6 same bit stays", d, 32'h1 << 9);
    step(1'b1, A_PEND, 32'h1 << 9, 1'b1, TGT, 7);
    rd(A_PEND, d); chk("R6 other bit", d, 32'h1 << 7);
    step(1'b1, A_STAT, SUMB, 1'b1, TGT, 3);
    rd(A_STAT, d); chk("R6 summary stays", d, SUMB);
    rd(A_PEND, d); chk("R6 pending", d, 32'h88);

    // R7 live INTx in status
    for (int x = 0; x < 16; x++) begin
      intxIn = 4'(x);
      rd(A_STAT, d); chk("R7 intx levels", d, SUMB | (32'(x) << 16));
    end
    intxIn = '0;

    // R8 irq sweep
    for (int s = 0; s < 2; s++) begin
      if (s == 0) wr(A_STAT, SUMB);
      else msi(TGT, 0);
      for (int mm = 0; mm < 2; mm++) begin
        for (int im = 0; im < 16; im++) begin
          wr(A_MASK, (32'(mm) << 23) | (32'(im) << 16));
          for (int x = 0; x < 16; x++) begin
            intxIn = 4'(x);
            #1;
            chk("R8 irqOut", {31'b0, irqOut},
                {31'b0, ((s == 1) && (mm == 0)) || ((4'(x) & ~4'(im)) != 4'h0)});
          end
          intxIn = '0;
        end
      end
    end

    // R10 unmapped offsets and read latency
    pendExp = 32'h89;
    wr(A_MASK, 32'h0080_0000);
    for (int u = 0; u < 8; u++) begin
      logic [11:0] ua;
      ua = (u == 0) ? 12'h0c0 : (u == 1) ? 12'h000 : (u == 2) ? 12'h428 :
           (u == 3) ? 12'h434 : (u == 4) ? 12'h41c : (u == 5) ? 12'h421 :
           (u == 6) ? 12'h42d : 12'hfff;
      wr(ua, 32'hFFFF_FFFF);
      rd(ua, d); chk("R10 unmapped zero", d, 32'h0);
    end
    rd(A_MASK, d);  chk("R10 mask unchanged", d, 32'h0080_0000);
    rd(A_TADDR, d); chk("R10 target unchanged", d, TGT);
    rd(A_PEND, d);  chk("R10 pending unchanged", d, pendExp);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = A_TADDR; regWrData = 32'hCAFE_0004;
    @(negedge clk);
    regWrEn = 1'b0; regRdEn = 1'b1;
    @(negedge clk);
    regRdEn = 1'b0;
    chk("R10 one-cycle read", regRdData, 32'hCAFE_0004);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule